// File: doc/BRIEF.md
# Fully Associative LRU Stack Tracker

This block follows the tag contents of one fully associative cache set of `N_WAYS` lines under least-recently-used replacement. It keeps an explicit age-ordered stack of resident block tags: slot 0 is the most recently used and slot `N_WAYS-1` the least recently used. A stack slot is an age rank, not a physical line number. Each cycle the block may take one reference, a tag qualified by a strobe. In the same cycle it reports whether the reference hit and, for a miss, whether a resident block is displaced and which one. The stack itself is updated on the next rising clock edge.

A hit moves the referenced tag to slot 0. Only the entries that were younger than it move one slot older, and the entries older than it keep their slots. A miss moves every entry one slot older and writes the new tag into slot 0. When all lines were occupied, the tag that was in the oldest slot falls out and is reported as the victim. Empty lines hold an all-ones tag with a cleared valid flag. That all-ones value is therefore never accepted as a reference. Data storage, refill, set indexing and write policy are handled elsewhere. A cache with several sets uses one tracker per set.

An occupancy state machine records how full the set is. Its states are `OCC_EMPTY`, `OCC_FILLING` and `OCC_FULL`. The transitions are:
- `first_fill`: from `OCC_EMPTY` on a miss, going to `OCC_FILLING`, or to `OCC_FULL` when `N_WAYS` is 1.
- `fill_step`: from `OCC_FILLING` to `OCC_FILLING` on a miss while more than one line is still free.
- `fill_done`: from `OCC_FILLING` to `OCC_FULL` on the miss that takes the last free line.
- `hold`: any state stays where it is on a hit, on an idle cycle or on a rejected reference. `OCC_FULL` also stays on a miss.

Reset returns the machine to `OCC_EMPTY`.

Top module: `lru_stack_tracker`

## Requirements
- R1: After reset, all `stack_valid` bits are 0 and every slot of `stack_tags` reads all-ones. With no reference, `hit` and `evict_valid` are 0.
- R2: In the same cycle as an accepted reference, `hit` is 1 exactly when a valid slot holds `ref_tag`.
- R3: After a hit on slot k, slot 0 holds the referenced tag and, for each slot j with 1 <= j <= k, slot j holds the tag that slot j-1 held before.
- R4: A hit leaves every slot older than the hit slot unchanged. A hit on slot 0 leaves the whole stack unchanged.
- R5: After a miss, slot 0 holds the new tag and, for every j >= 1, slot j holds the tag that slot j-1 held before.
- R6: A miss while all `N_WAYS` slots are valid drives `evict_valid`=1 in the same cycle, with `evict_tag` equal to the tag in slot `N_WAYS-1`. `evict_tag` reads 0 whenever `evict_valid` is 0.
- R7: A miss while some slot is invalid drives `evict_valid`=0, and the number of valid slots grows by one.
- R8: A strobed reference whose tag is all-ones is rejected. `hit` and `evict_valid` stay 0 and the stack does not change.
- R9: While `ref_valid` is 0, `hit` and `evict_valid` are 0 and the stack does not change.
- R10: No tag is ever held in two valid slots at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_valid | input | 1 | Reference strobe |
| ref_tag | input | TAG_W | Block tag of the reference |
| hit | output | 1 | Reference found in the set (same cycle) |
| evict_valid | output | 1 | Miss displaces a resident block (same cycle) |
| evict_tag | output | TAG_W | Tag of the displaced block, 0 when none |
| stack_tags | output | N_WAYS*TAG_W | Age-ordered tags; slot i at bits [i*TAG_W +: TAG_W], slot 0 youngest |
| stack_valid | output | N_WAYS | Bit i set when slot i holds a block |

## Verification
Two things can happen in one cycle: the victim is reported from the oldest slot, and the new tag is inserted at the front while every entry shifts. A hit on that same oldest slot reuses the same shift path but must not report a victim. The bench provokes both cases. It fills the set and then references a fresh tag, and it also references the tag currently sitting in the oldest slot. The eviction outputs are judged before the edge and the whole stack after it. A queue model in the bench supplies the expected victim and ordering. Long pseudo-random streams over a small tag pool then mix the two cases with hits on the youngest and middle slots.

// File: rtl/lru_tracker_pkg.sv
package lru_tracker_pkg;

    // Occupancy of the tracked set
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_FILLING = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/lru_tag_match.sv
module lru_tag_match #(
    parameter int N_WAYS = 4,
    parameter int TAG_W  = 16,
    localparam int IDX_W = (N_WAYS > 1) ? $clog2(N_WAYS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_WAYS-1:0][TAG_W-1:0] slot_tags,
    input  logic [N_WAYS-1:0]            slot_valid,
    input  logic [TAG_W-1:0]             probe_tag,
    output logic [N_WAYS-1:0]            match_vec,
    output logic                         any_match,
    output logic [IDX_W-1:0]             match_pos
);

    // One comparator per stack slot
    for (genvar i = 0; i < N_WAYS; i++) begin : g_cmp
        assign match_vec[i] = slot_valid[i] && (slot_tags[i] == probe_tag);
    end

    assign any_match = |match_vec;

    always_comb begin
        match_pos = '0;
        for (int i = N_WAYS - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                match_pos = IDX_W'(i);
            end
        end
    end

    // R10: a tag may be resident in at most one slot
    assert_unique_tags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec))
        else $error("duplicate resident tag");

endmodule

// File: rtl/lru_stack_shift.sv
module lru_stack_shift #(
    parameter int N_WAYS = 4,
    parameter int TAG_W  = 16,
    localparam int IDX_W = (N_WAYS > 1) ? $clog2(N_WAYS) : 1
) (
    input  logic [N_WAYS-1:0][TAG_W-1:0] cur_tags,
    input  logic [N_WAYS-1:0]            cur_valid,
    input  logic [TAG_W-1:0]             ins_tag,
    input  logic [IDX_W-1:0]             lift_pos,
    output logic [N_WAYS-1:0][TAG_W-1:0] nxt_tags,
    output logic [N_WAYS-1:0]            nxt_valid
);

    // Slot 0 takes the referenced tag. Slots up to lift_pos take their
    // younger neighbour. Slots beyond lift_pos keep their contents.
    for (genvar i = 0; i < N_WAYS; i++) begin : g_slot
        if (i == 0) begin : g_front
            assign nxt_tags[i]  = ins_tag;
            assign nxt_valid[i] = 1'b1;
        end else begin : g_rest
            logic take_younger;
            assign take_younger = (IDX_W'(i) <= lift_pos);
            assign nxt_tags[i]  = take_younger ? cur_tags[i-1]  : cur_tags[i];
            assign nxt_valid[i] = take_younger ? cur_valid[i-1] : cur_valid[i];
        end
    end

endmodule

// File: rtl/lru_stack_tracker.sv
module lru_stack_tracker
    import lru_tracker_pkg::*;
#(
    parameter int N_WAYS = 4,
    parameter int TAG_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ref_valid,
    input  logic [TAG_W-1:0]         ref_tag,
    output logic                     hit,
    output logic                     evict_valid,
    output logic [TAG_W-1:0]         evict_tag,
    output logic [N_WAYS*TAG_W-1:0]  stack_tags,
    output logic [N_WAYS-1:0]        stack_valid
);

    localparam int IDX_W = (N_WAYS > 1) ? $clog2(N_WAYS) : 1;
    localparam int CNT_W = $clog2(N_WAYS + 1);
    localparam logic [TAG_W-1:0] EMPTY_TAG = {TAG_W{1'b1}};
    localparam logic [IDX_W-1:0] OLDEST    = IDX_W'(N_WAYS - 1);
    localparam logic [CNT_W-1:0] LAST_FREE = CNT_W'(N_WAYS - 1);

    logic [N_WAYS-1:0][TAG_W-1:0] tags_q, tags_d;
    logic [N_WAYS-1:0]            valid_q, valid_d;
    logic [N_WAYS-1:0]            match_vec;
    logic                         any_match;
    logic [IDX_W-1:0]             match_pos, lift_pos;
    logic                         accept, is_hit, is_miss;

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] fill_q, fill_d;

    // Reference qualification
    assign accept  = ref_valid && (ref_tag != EMPTY_TAG);
    assign is_hit  = accept && any_match;
    assign is_miss = accept && !any_match;
    assign lift_pos = any_match ? match_pos : OLDEST;

    lru_tag_match #(.N_WAYS(N_WAYS), .TAG_W(TAG_W)) i_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_tags  (tags_q),
        .slot_valid (valid_q),
        .probe_tag  (ref_tag),
        .match_vec  (match_vec),
        .any_match  (any_match),
        .match_pos  (match_pos)
    );

    lru_stack_shift #(.N_WAYS(N_WAYS), .TAG_W(TAG_W)) i_shift (
        .cur_tags  (tags_q),
        .cur_valid (valid_q),
        .ins_tag   (ref_tag),
        .lift_pos  (lift_pos),
        .nxt_tags  (tags_d),
        .nxt_valid (valid_d)
    );

    // Stack storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WAYS; i++) begin
                tags_q[i] <= EMPTY_TAG;
            end
            valid_q <= '0;
        end else if (accept) begin
            tags_q  <= tags_d;
            valid_q <= valid_d;
        end
    end

    // Occupancy state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // Occupancy transitions
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (is_miss) begin                       // first_fill
                    fill_d  = CNT_W'(1);
                    state_d = (N_WAYS == 1) ? OCC_FULL : OCC_FILLING;
                end
            end
            OCC_FILLING: begin
                if (is_miss) begin
                    fill_d = fill_q + CNT_W'(1);
                    if (fill_q == LAST_FREE) begin       // fill_done
                        state_d = OCC_FULL;
                    end                                  // else fill_step
                end
            end
            OCC_FULL: begin
                state_d = OCC_FULL;                      // hold
            end
            default: begin
                state_d = OCC_EMPTY;
                fill_d  = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        hit         = is_hit;
        evict_valid = is_miss && (state_q == OCC_FULL);
        evict_tag   = evict_valid ? tags_q[N_WAYS-1] : '0;
        stack_tags  = tags_q;
        stack_valid = valid_q;
    end

    // R1: an empty set has no valid slot
    assert_empty_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY) |-> (valid_q == '0))
        else $error("valid slot while empty");

    // R6/R7: victim reported exactly when the oldest slot is occupied
    assert_victim_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_miss |-> (evict_valid == valid_q[N_WAYS-1]))
        else $error("victim flag disagrees with stack");

    // R3/R5: accepted reference lands in the youngest slot
    assert_front_insert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tags_q[0] == $past(ref_tag)) && valid_q[0])
        else $error("reference not at front");

    // R4: hit on youngest slot leaves the stack alone
    assert_youngest_hit_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hit && match_vec[0]) |=> $stable(tags_q) && $stable(valid_q))
        else $error("youngest hit changed stack");

    // R8: the empty marker is rejected
    assert_marker_rejected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_tag == EMPTY_TAG) |=> $stable(tags_q) && $stable(valid_q))
        else $error("marker reference changed stack");

    // R9: no strobe, no change
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |-> !hit && !evict_valid)
        else $error("output without strobe");

endmodule

// File: tb/test_lru_stack_tracker.sv
`timescale 1ns/1ps
module test_lru_stack_tracker;

    localparam int N  = 4;
    localparam int TW = 16;
    localparam logic [TW-1:0] MARK = {TW{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_valid = 1'b0;
    logic [TW-1:0]     ref_tag = '0;
    logic              hit, evict_valid;
    logic [TW-1:0]     evict_tag;
    logic [N*TW-1:0]   stack_tags;
    logic [N-1:0]      stack_valid;

    int total = 0;
    int fails = 0;
    bit done  = 0;
    logic [TW-1:0] model[$];

    always #2.5 clk = ~clk;

    lru_stack_tracker #(.N_WAYS(N), .TAG_W(TW)) i_lru_stack_tracker (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_tag(ref_tag),
        .hit(hit), .evict_valid(evict_valid), .evict_tag(evict_tag),
        .stack_tags(stack_tags), .stack_valid(stack_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N*TW-1:0] exp_tags();
        logic [N*TW-1:0] v;
        for (int i = 0; i < N; i++)
            v[i*TW +: TW] = (i < model.size()) ? model[i] : MARK;
        return v;
    endfunction

    function automatic logic [N-1:0] exp_valid();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (i < model.size());
        return v;
    endfunction

    task automatic check_stack(input string req);
        chk(stack_tags == exp_tags(), {req, " stack tags"}, 64'(stack_tags), 64'(exp_tags()));
        chk(stack_valid == exp_valid(), {req, " stack valid"}, 64'(stack_valid), 64'(exp_valid()));
    endtask

    // One reference: outputs checked before the edge, stack after it
    task automatic do_ref(input logic [TW-1:0] tag, input string req);
        int idx;
        bit e_hit, e_ev;
        logic [TW-1:0] e_tag;
        idx = -1;
        e_ev = 0;
        e_tag = '0;
        for (int i = 0; i < model.size(); i++) if (model[i] == tag) idx = i;
        e_hit = (tag != MARK) && (idx >= 0);
        if (tag != MARK && idx < 0 && model.size() == N) begin
            e_ev = 1;
            e_tag = model[N-1];
        end
        @(negedge clk);
        ref_valid = 1'b1;
        ref_tag   = tag;
        #1;
        chk(hit == e_hit, {req, " hit"}, 64'(hit), 64'(e_hit));
        chk(evict_valid == e_ev, {req, " evict_valid"}, 64'(evict_valid), 64'(e_ev));
        chk(evict_tag == e_tag, {req, " evict_tag"}, 64'(evict_tag), 64'(e_tag));
        if (tag != MARK) begin
            if (idx >= 0) model.delete(idx);
            else if (model.size() == N) void'(model.pop_back());
            model.push_front(tag);
        end
        @(posedge clk);
        #1;
        ref_valid = 1'b0;
        check_stack(req);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model.delete();
        #1;
        check_stack("R1");
        chk(!hit && !evict_valid, "R1 idle outputs", 64'({hit, evict_valid}), 64'(0));
    endtask

    task automatic t_fill();
        do_ref(16'h0010, "R7");
        do_ref(16'h0020, "R5");
        do_ref(16'h0030, "R7");
        do_ref(16'h0040, "R7");
    endtask

    task automatic t_hit_youngest();
        do_ref(16'h0040, "R4");
        do_ref(16'h0040, "R4");
    endtask

    task automatic t_hit_oldest();
        do_ref(16'h0010, "R3");
    endtask

    task automatic t_hit_middle();
        do_ref(16'h0030, "R4");
    endtask

    task automatic t_evict();
        do_ref(16'h0050, "R6");
        do_ref(16'h0060, "R6");
        do_ref(model[N-1], "R2");
    endtask

    task automatic t_marker();
        do_ref(MARK, "R8");
    endtask

    task automatic t_idle();
        @(negedge clk);
        ref_valid = 1'b0;
        ref_tag   = model[0];
        #1;
        chk(!hit && !evict_valid, "R9 outputs", 64'({hit, evict_valid}), 64'(0));
        repeat (3) @(posedge clk);
        #1;
        check_stack("R9");
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_ref(16'(lfsr % 7) + 16'h0100, "R2");
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fill();
        t_hit_youngest();
        t_hit_oldest();
        t_hit_middle();
        t_evict();
        t_marker();
        t_idle();
        t_reset();
        t_random();
        t_reset();
        t_fill();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule